// File: doc/BRIEF.md
# Filtered Event Counter with Threshold and Burst Detection

This block is one slice of a performance-monitoring unit. Each cycle it receives a small scalar event count and an event bitmask from an execution unit, together with the privilege level the core is running at. A filter stage turns these into a per-cycle increment for a 48-bit counter. The stage masks the bitmask, takes its population count and adds the scalar count. It can compare the total against a threshold, invert that comparison, detect rising edges, and qualify the result by privilege level. The counter wraps on overflow, pulses an output, sets a sticky flag and can raise an interrupt.

The settings sit in a configuration register that is loaded in one cycle. Its fields are the mode-enable mask, the unit mask, the threshold, and the invert, edge and interrupt-enable bits. Software can preset the counter, which is how overflow is normally armed, and can clear the sticky flag. With the threshold left at zero the slice counts every event. With a nonzero threshold it counts cycles in which occupancy reaches a level. In edge mode it counts bursts.

Edge mode uses a two-state machine. `EDGE_LOW` means the qualified condition was false in the previous cycle, and it is the reset state. `EDGE_HIGH` means the condition was true. The machine moves from `EDGE_LOW` to `EDGE_HIGH` when the condition is true, and from `EDGE_HIGH` to `EDGE_LOW` when it is false. Otherwise it stays where it is. The machine updates every cycle, whatever the edge bit is set to.

Top module: `perf_filter_counter`

## Requirements
- R1: After reset the counter, sticky flag, interrupt and overflow pulse are all 0. Every configuration field is 0, so no privilege level is enabled and events do not count.
- R2: When `cfg_we` is high, the configuration loads from `cfg_wdata` and is in effect from the next cycle. The field layout is: bits [2:0] mode mask, [10:3] unit mask, [14:11] threshold, [15] invert, [16] edge, [17] interrupt enable.
- R3: The per-cycle total is `evt_count` plus the number of set bits in `evt_bits & unit_mask`. With a zero unit mask, only `evt_count` contributes.
- R4: When the threshold is 0 and edge is off, the counter adds the full total each enabled cycle. The invert bit has no effect in this case.
- R5: When the threshold is nonzero and invert is 0, the counter adds 1 in a cycle where total >= threshold, and 0 otherwise.
- R6: When the threshold is nonzero and invert is 1, the counter adds 1 in a cycle where total < threshold, and 0 otherwise.
- R7: Privilege 0 is enabled by mode bit 0, privilege 1 by mode bit 1, and privileges 2 and 3 by mode bit 2. In a disabled privilege level the counter holds its value.
- R8: When edge is on, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. The qualified condition is the R5/R6 result, or total != 0 when the threshold is 0, ANDed with the mode enable. The stored previous value resets to false.
- R9: When `ctr_we` is high, the counter loads `ctr_wdata` and that cycle's increment is dropped.
- R10: An increment that carries past 2^48-1 wraps modulo 2^48, and counting continues afterwards. `ovf_pulse` is high for exactly the one cycle in which the wrapped value is first visible, and the sticky flag sets.
- R11: `ovf_clr` clears the sticky flag. An overflow in the same cycle wins, so the flag stays set.
- R12: `irq` is high exactly when the sticky flag and the interrupt-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_count | input | 3 | Scalar event count this cycle (0 to 7) |
| evt_bits | input | 8 | Per-lane event bitmask from the unit |
| priv | input | 2 | Current privilege level |
| cfg_we | input | 1 | Load configuration register |
| cfg_wdata | input | 18 | Configuration value (layout in R2) |
| ctr_we | input | 1 | Load counter |
| ctr_wdata | input | 48 | Counter load value |
| ovf_clr | input | 1 | Clear sticky overflow flag |
| count | output | 48 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle pulse on each wrap |
| irq | output | 1 | Overflow interrupt request |

## Verification
Threshold boundaries get the most attention: totals equal to and one below the threshold are checked in both polarities, so an off-by-one comparison or a wrong invert polarity shows up as a count of 1 where 0 is due, or 0 where 1 is due. In edge mode, bursts longer than one cycle and bursts right after configuration are counted. A detector with a stale or wrongly reset state would count every active cycle, or would miss the first burst. Privilege levels 2 and 3 both have to follow the shared mode bit. Overflow is tested at an exact wrap to zero and at a wrap past zero. Bit loss in the carry, a lingering pulse, a flag that fails to stick, or an interrupt that ignores its enable would each give the wrong value at the sampled cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;

    localparam logic [1:0] PRIV_LVL0 = 2'd0;
    localparam logic [1:0] PRIV_LVL1 = 2'd1;

endpackage

// File: rtl/pfc_event_sum.sv
module pfc_event_sum #(
    parameter int RAW_W  = 3,
    parameter int MASK_W = 8,
    parameter int TOT_W  = 4
) (
    input  logic [RAW_W-1:0]  evt_count,
    input  logic [MASK_W-1:0] evt_bits,
    input  logic [MASK_W-1:0] unit_mask,
    output logic [TOT_W-1:0]  total
);

    logic [MASK_W-1:0] picked;
    assign picked = evt_bits & unit_mask;

    always_comb begin
        total = TOT_W'(evt_count);
        for (int i = 0; i < MASK_W; i++) begin
            total = total + TOT_W'(picked[i]);
        end
    end

endmodule

// File: rtl/pfc_filter.sv
module pfc_filter
    import pfc_pkg::*;
#(
    parameter int TOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] total,
    input  logic [TOT_W-1:0] thresh,
    input  logic             invert,
    input  logic             edge_en,
    input  logic             mode_ok,
    output logic [TOT_W-1:0] step
);

    edge_state_t state_q, state_nx;
    logic             cond;
    logic             qual;
    logic [TOT_W-1:0] level;

    always_comb begin
        if (thresh == '0) begin
            cond  = (total != '0);
            level = total;
        end else begin
            cond  = (total >= thresh) ^ invert;
            level = TOT_W'(cond);
        end
        qual = mode_ok & cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        step     = '0;
        unique case (state_q)
            EDGE_LOW: begin
                state_nx = qual ? EDGE_HIGH : EDGE_LOW;
                if (edge_en) step = TOT_W'(qual);
            end
            EDGE_HIGH: begin
                state_nx = qual ? EDGE_HIGH : EDGE_LOW;
            end
            default: state_nx = EDGE_LOW;
        endcase
        if (!edge_en) step = mode_ok ? level : '0;
    end

endmodule

// File: rtl/pfc_accum.sv
module pfc_accum #(
    parameter int CNT_W = 48,
    parameter int TOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             ovf_flag,
    output logic             irq
);

    logic [CNT_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, count} + (CNT_W+1)'(step);
    assign wrap = sum[CNT_W] & ~load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            ovf_pulse <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            count     <= load ? load_val : sum[CNT_W-1:0];
            ovf_pulse <= wrap;
            if (wrap)          ovf_flag <= 1'b1;
            else if (flag_clr) ovf_flag <= 1'b0;
        end
    end

    assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/perf_filter_counter.sv
module perf_filter_counter
    import pfc_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int RAW_W  = 3,
    parameter int MASK_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RAW_W-1:0]     evt_count,
    input  logic [MASK_W-1:0]    evt_bits,
    input  logic [1:0]           priv,
    input  logic                 cfg_we,
    input  logic [MASK_W+$clog2((2**RAW_W)+MASK_W)+5:0] cfg_wdata,
    input  logic                 ctr_we,
    input  logic [CNT_W-1:0]     ctr_wdata,
    input  logic                 ovf_clr,
    output logic [CNT_W-1:0]     count,
    output logic                 ovf_flag,
    output logic                 ovf_pulse,
    output logic                 irq
);

    localparam int TOT_W   = $clog2((2**RAW_W) + MASK_W);
    localparam int MODE_LO = 0;
    localparam int MASK_LO = 3;
    localparam int THR_LO  = MASK_LO + MASK_W;
    localparam int INV_B   = THR_LO + TOT_W;
    localparam int EDGE_B  = INV_B + 1;
    localparam int IE_B    = INV_B + 2;

    logic [2:0]        cfg_mode;
    logic [MASK_W-1:0] cfg_umask;
    logic [TOT_W-1:0]  cfg_thr;
    logic              cfg_inv;
    logic              cfg_edge;
    logic              cfg_ie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode  <= '0;
            cfg_umask <= '0;
            cfg_thr   <= '0;
            cfg_inv   <= 1'b0;
            cfg_edge  <= 1'b0;
            cfg_ie    <= 1'b0;
        end else if (cfg_we) begin
            cfg_mode  <= cfg_wdata[MODE_LO +: 3];
            cfg_umask <= cfg_wdata[MASK_LO +: MASK_W];
            cfg_thr   <= cfg_wdata[THR_LO +: TOT_W];
            cfg_inv   <= cfg_wdata[INV_B];
            cfg_edge  <= cfg_wdata[EDGE_B];
            cfg_ie    <= cfg_wdata[IE_B];
        end
    end

    logic mode_ok;
    always_comb begin
        unique case (priv)
            PRIV_LVL0: mode_ok = cfg_mode[0];
            PRIV_LVL1: mode_ok = cfg_mode[1];
            default:   mode_ok = cfg_mode[2];
        endcase
    end

    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] step;

    pfc_event_sum #(.RAW_W(RAW_W), .MASK_W(MASK_W), .TOT_W(TOT_W)) u_sum (
        .evt_count (evt_count),
        .evt_bits  (evt_bits),
        .unit_mask (cfg_umask),
        .total     (total)
    );

    pfc_filter #(.TOT_W(TOT_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .total   (total),
        .thresh  (cfg_thr),
        .invert  (cfg_inv),
        .edge_en (cfg_edge),
        .mode_ok (mode_ok),
        .step    (step)
    );

    pfc_accum #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load      (ctr_we),
        .load_val  (ctr_wdata),
        .flag_clr  (ovf_clr),
        .irq_en    (cfg_ie),
        .count     (count),
        .ovf_pulse (ovf_pulse),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/perf_filter_counter_chk.sv
module perf_filter_counter_chk #(
    parameter int CNT_W    = 48,
    parameter int STEP_MAX = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctr_we,
    input logic [CNT_W-1:0] ctr_wdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_pulse,
    input logic             ovf_flag,
    input logic             irq,
    input logic             edge_on
);

    // R9: a load replaces the counter value outright
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |=> count == $past(ctr_wdata));

    // R10: the counter never advances by more than one cycle's maximum total
    p_step_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctr_we |=> (count - $past(count)) <= CNT_W'(STEP_MAX));

    // R10: a wrap lands on a small value and sets the sticky flag
    p_wrap_small_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count <= CNT_W'(STEP_MAX)) && ovf_flag);

    // R10: the pulse lasts one cycle
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    // R12: the interrupt needs the sticky flag
    p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

    // R8: in edge mode each cycle adds at most one
    p_edge_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && !ctr_we) |=> (count - $past(count)) <= CNT_W'(1));

endmodule

bind perf_filter_counter perf_filter_counter_chk #(
    .CNT_W    (CNT_W),
    .STEP_MAX ((2**RAW_W) - 1 + MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctr_we    (ctr_we),
    .ctr_wdata (ctr_wdata),
    .count     (count),
    .ovf_pulse (ovf_pulse),
    .ovf_flag  (ovf_flag),
    .irq       (irq),
    .edge_on   (cfg_edge)
);

// File: tb/perf_filter_counter_test.sv
`timescale 1ns/1ps
module perf_filter_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_count = '0;
    logic [7:0]  evt_bits = '0;
    logic [1:0]  priv = '0;
    logic        cfg_we = 1'b0;
    logic [17:0] cfg_wdata = '0;
    logic        ctr_we = 1'b0;
    logic [47:0] ctr_wdata = '0;
    logic        ovf_clr = 1'b0;
    logic [47:0] count;
    logic        ovf_flag, ovf_pulse, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    perf_filter_counter uut (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .evt_bits(evt_bits),
        .priv(priv), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctr_we(ctr_we),
        .ctr_wdata(ctr_wdata), .ovf_clr(ovf_clr), .count(count),
        .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse), .irq(irq)
    );

    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] umask;
        logic [3:0] thr;
        logic       inv;
        logic [2:0] cnt;
        logic [7:0] bits;
        logic [1:0] pv;
        logic [3:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VEC [0:13] = '{
        '{3'd7, 8'hFF, 4'd0,  1'b0, 3'd3, 8'h0F, 2'd0, 4'd7, 4'd3},  // R3 sum
        '{3'd7, 8'h03, 4'd0,  1'b0, 3'd0, 8'hFF, 2'd0, 4'd2, 4'd3},  // R3 mask
        '{3'd7, 8'hFF, 4'd0,  1'b1, 3'd2, 8'h01, 2'd0, 4'd3, 4'd4},  // R4 invert ignored
        '{3'd7, 8'hFF, 4'd4,  1'b0, 3'd2, 8'h03, 2'd0, 4'd1, 4'd5},  // R5 equal
        '{3'd7, 8'hFF, 4'd4,  1'b0, 3'd1, 8'h03, 2'd0, 4'd0, 4'd5},  // R5 below
        '{3'd7, 8'hFF, 4'd4,  1'b1, 3'd1, 8'h03, 2'd0, 4'd1, 4'd6},  // R6 below
        '{3'd7, 8'hFF, 4'd4,  1'b1, 3'd2, 8'h03, 2'd0, 4'd0, 4'd6},  // R6 equal
        '{3'd1, 8'hFF, 4'd0,  1'b0, 3'd5, 8'h00, 2'd1, 4'd0, 4'd7},  // R7 disabled
        '{3'd2, 8'hFF, 4'd0,  1'b0, 3'd5, 8'h00, 2'd1, 4'd5, 4'd7},  // R7 lvl1
        '{3'd4, 8'hFF, 4'd0,  1'b0, 3'd1, 8'h00, 2'd3, 4'd1, 4'd7},  // R7 lvl3
        '{3'd4, 8'hFF, 4'd0,  1'b0, 3'd6, 8'h00, 2'd2, 4'd6, 4'd7},  // R7 lvl2
        '{3'd3, 8'hFF, 4'd0,  1'b0, 3'd7, 8'hFF, 2'd3, 4'd0, 4'd7},  // R7 lvl3 off
        '{3'd7, 8'hFF, 4'd15, 1'b0, 3'd7, 8'hFF, 2'd0, 4'd1, 4'd5},  // R5 max
        '{3'd7, 8'h00, 4'd0,  1'b0, 3'd4, 8'hFF, 2'd0, 4'd4, 4'd3}   // R3 zero mask
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [17:0] mkcfg(input logic [2:0] m, input logic [7:0] um,
                                          input logic [3:0] th, input logic iv,
                                          input logic ed, input logic ie);
        return {ie, ed, iv, th, um, m};
    endfunction

    // load configuration and counter in one cycle with no events (R2, R9)
    task automatic setup(input logic [17:0] c, input logic [47:0] start);
        cfg_we = 1'b1; cfg_wdata = c;
        ctr_we = 1'b1; ctr_wdata = start;
        evt_count = '0; evt_bits = '0;
        tick();
        cfg_we = 1'b0; ctr_we = 1'b0;
    endtask

    task automatic drive(input logic [2:0] c, input logic [7:0] b);
        evt_count = c; evt_bits = b;
        tick();
        evt_count = '0; evt_bits = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 count", 64'(count), 64'd0);
        chk("R1 flag", 64'(ovf_flag), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 pulse", 64'(ovf_pulse), 64'd0);
        priv = 2'd0;
        drive(3'd7, 8'hFF);
        chk("R1 no mode enabled", 64'(count), 64'd0);

        // table walk: R2..R7
        for (int i = 0; i < 14; i++) begin
            setup(mkcfg(VEC[i].mode, VEC[i].umask, VEC[i].thr, VEC[i].inv, 1'b0, 1'b0), 48'd0);
            priv = VEC[i].pv;
            drive(VEC[i].cnt, VEC[i].bits);
            checks++;
            if (count !== 48'(VEC[i].exp)) begin
                fails++;
                $display("FAIL R%0d table[%0d]: actual %0d expected %0d",
                         VEC[i].rq, i, count, VEC[i].exp);
            end
        end
        priv = 2'd0;

        // R8: burst counting with threshold 2
        setup(mkcfg(3'd7, 8'hFF, 4'd2, 1'b0, 1'b1, 1'b0), 48'd0);
        drive(3'd3, 8'h00); drive(3'd3, 8'h00); drive(3'd3, 8'h00);
        drive(3'd0, 8'h00);
        drive(3'd2, 8'h00); drive(3'd5, 8'h00);
        drive(3'd1, 8'h00);
        drive(3'd2, 8'h00);
        chk("R8 bursts thr2", 64'(count), 64'd3);

        // R8: burst counting with threshold 0 (condition total != 0)
        setup(mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b1, 1'b0), 48'd0);
        drive(3'd1, 8'h00); drive(3'd4, 8'h00);
        drive(3'd0, 8'h00); drive(3'd0, 8'h00);
        drive(3'd2, 8'h00);
        chk("R8 bursts thr0", 64'(count), 64'd2);

        // R9: load beats increment
        setup(mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b0), 48'd0);
        ctr_we = 1'b1; ctr_wdata = 48'd100;
        drive(3'd5, 8'h00);
        ctr_we = 1'b0;
        chk("R9 load priority", 64'(count), 64'd100);

        // R10: wrap past zero
        setup(mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b0), 48'hFFFF_FFFF_FFFE);
        drive(3'd3, 8'h00);
        chk("R10 wrap value", 64'(count), 64'd1);
        chk("R10 pulse", 64'(ovf_pulse), 64'd1);
        chk("R10 flag", 64'(ovf_flag), 64'd1);
        chk("R12 irq disabled", 64'(irq), 64'd0);
        drive(3'd2, 8'h00);
        chk("R10 keeps counting", 64'(count), 64'd3);
        chk("R10 pulse drops", 64'(ovf_pulse), 64'd0);
        chk("R10 flag sticky", 64'(ovf_flag), 64'd1);

        // R12: enable interrupt
        cfg_we = 1'b1; cfg_wdata = mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b1);
        tick();
        cfg_we = 1'b0;
        chk("R12 irq", 64'(irq), 64'd1);

        // R11: clear flag
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        chk("R11 flag cleared", 64'(ovf_flag), 64'd0);
        chk("R12 irq follows", 64'(irq), 64'd0);

        // R10: exact wrap to zero
        setup(mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b1), 48'hFFFF_FFFF_FFFF);
        drive(3'd1, 8'h00);
        chk("R10 exact wrap", 64'(count), 64'd0);
        chk("R10 exact pulse", 64'(ovf_pulse), 64'd1);

        // R11: set wins over clear
        setup(mkcfg(3'd7, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b1), 48'hFFFF_FFFF_FFFF);
        ovf_clr = 1'b1;
        drive(3'd1, 8'h00);
        ovf_clr = 1'b0;
        chk("R11 set wins", 64'(ovf_flag), 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule